// File: doc/BRIEF.md
# Multi-Processor Interrupt Status Controller

This block gathers interrupt requests for up to four processors into one shared 64-bit pending register. Local software can overwrite the pending register outright, or change it atomically by writing a word to a set port or a clear port, where only the 1 bits of the word take effect. Devices on the remote I/O side cannot reach those ports. They reach the register through one command register, and each command sets or clears a single bit chosen by an index.

Each processor has its own 64-bit enable mask. The pending bits are split into six fixed groups, and each group drives one of six priority lines (line 0 to line 5) into every processor. A line is raised for a processor when some pending bit of its group is also enabled in that processor's mask. Hardware event inputs, such as an interval timer tick and memory error reports, set their own pending bits on a rising edge.

The local bus is a plain valid/write/address/data interface, and register reads return their data one cycle later.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the pending register, all four masks, all read data and every CPU line are zero.
- R2: A local write to word address 0 replaces the whole pending register with the write data.
- R3: A local write to word address 1 sets exactly the pending bits that are 1 in the data. Bits that are 0 in the data keep their value.
- R4: A local write to word address 2 clears exactly the pending bits that are 1 in the data. Bits that are 0 in the data keep their value.
- R5: A remote write to address 0x80 sets pending bit `wdata[5:0]` when `wdata[8]` is 1, and clears that bit when `wdata[8]` is 0. A remote write to any other address has no effect.
- R6: When a set source and a clear source hit the same pending bit in the same cycle, the bit ends up set.
- R7: The mask of CPU n is written and read at word address 4+n.
- R8: CPU line k (bit `cpu_ip[6*n+k]`) is high when some bit in the group of line k is both pending and enabled in the mask of CPU n. The groups are: line 0 bits 15:0, line 1 bits 31:16, line 2 bits 47:32, line 3 bits 55:48, line 4 bits 59:56, line 5 bits 63:60.
- R9: CPU lines are registered. They reflect the pending register and the masks one cycle after either of them changes.
- R10: A rising edge on `hw_evt[i]` sets pending bit 59+i. Bit 59 is the timer, on line 4. Bits 60 to 62 are errors, on line 5. A level held high does not set the bit again after it has been cleared.
- R11: A local read of address 0, 1 or 2 returns the pending register, and a read of 4+n returns the mask of CPU n. The data is valid on the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_valid | input | 1 | Local bus request |
| loc_write | input | 1 | 1 for write, 0 for read |
| loc_addr | input | 3 | Local word address |
| loc_wdata | input | 64 | Local write data |
| loc_rdata | output | 64 | Local read data, one cycle after the request |
| rem_valid | input | 1 | Remote write strobe |
| rem_addr | input | 8 | Remote register address |
| rem_wdata | input | 16 | Remote command word |
| hw_evt | input | 4 | Hardware event inputs, rising-edge sensitive |
| cpu_ip | output | 24 | Six priority lines per CPU, CPU n on bits 6n+5:6n |

## Verification
The fan-out is tested with masks that differ on each CPU: one mask with every bit enabled, one with only the error group, one that is empty, and one with a single bit. A pending pattern with bits in three groups then shows whether the group boundaries and the per-CPU masking are each correct. Atomic updates are tested in pairs that collide on the same cycle: local clear against remote set, local set against remote clear, and event against clear. These pairs separate set-wins priority from last-writer behaviour. Direct writes are followed by line samples one cycle apart to confirm the register stage. Remote writes to the wrong address, and a zero set word, check that unrelated bits are left alone.

// File: rtl/irq_ctrl_pkg.sv
`timescale 1ns/1ps
package irq_ctrl_pkg;
  localparam int ISR_W  = 64;
  localparam int NLINE  = 6;
  localparam int LOC_AW = 3;

  localparam logic [LOC_AW-1:0] A_ISR  = 3'd0;
  localparam logic [LOC_AW-1:0] A_SET  = 3'd1;
  localparam logic [LOC_AW-1:0] A_CLR  = 3'd2;
  localparam int                A_MASK = 4;

  // Upper bit of each line group; line k covers (top[k-1], top[k]]
  function automatic int grp_top(int l);
    case (l)
      0: grp_top = 15;
      1: grp_top = 31;
      2: grp_top = 47;
      3: grp_top = 55;
      4: grp_top = 59;
      default: grp_top = 63;
    endcase
  endfunction

  function automatic logic [ISR_W-1:0] grp_mask(int l);
    logic [ISR_W-1:0] m;
    int lo;
    lo = (l == 0) ? 0 : grp_top(l - 1) + 1;
    for (int b = 0; b < ISR_W; b++) m[b] = (b >= lo) && (b <= grp_top(l));
    return m;
  endfunction
endpackage

// File: rtl/irq_remote_decode.sv
`timescale 1ns/1ps
module irq_remote_decode
  import irq_ctrl_pkg::*;
#(
  parameter int          REM_AW  = 8,
  parameter int          REM_DW  = 16,
  parameter int          OP_BIT  = 8,
  parameter logic [7:0]  CMD_OFS = 8'h80
) (
  input  logic              rem_valid,
  input  logic [REM_AW-1:0] rem_addr,
  input  logic [REM_DW-1:0] rem_wdata,
  output logic [ISR_W-1:0]  rem_set,
  output logic [ISR_W-1:0]  rem_clr
);
  localparam int IDX_W = $clog2(ISR_W);

  logic             hit;
  logic [ISR_W-1:0] onehot;

  always_comb begin
    hit    = rem_valid && (rem_addr == REM_AW'(CMD_OFS));
    onehot = ISR_W'(1) << rem_wdata[IDX_W-1:0];
    rem_set = (hit &&  rem_wdata[OP_BIT]) ? onehot : '0;
    rem_clr = (hit && !rem_wdata[OP_BIT]) ? onehot : '0;
  end
endmodule

// File: rtl/irq_isr_core.sv
`timescale 1ns/1ps
module irq_isr_core
  import irq_ctrl_pkg::*;
#(
  parameter int NEVT     = 4,
  parameter int EVT_BASE = 59
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ISR_W-1:0] wr_data,
  input  logic [ISR_W-1:0] set_vec,
  input  logic [ISR_W-1:0] clr_vec,
  input  logic [NEVT-1:0]  hw_evt,
  output logic [ISR_W-1:0] isr_q
);
  logic [NEVT-1:0]  evt_d;
  logic [ISR_W-1:0] evt_set;
  logic [ISR_W-1:0] isr_d;
  logic [ISR_W-1:0] base;

  always_comb begin
    evt_set = '0;
    for (int i = 0; i < NEVT; i++)
      evt_set[EVT_BASE + i] = hw_evt[i] & ~evt_d[i];
  end

  // set sources are applied after clears so that set wins
  always_comb begin
    base  = wr_en ? wr_data : isr_q;
    isr_d = (base & ~clr_vec) | set_vec | evt_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      evt_d <= '0;
    end else begin
      isr_q <= isr_d;
      evt_d <= hw_evt;
    end
  end
endmodule

// File: rtl/irq_mask_bank.sv
`timescale 1ns/1ps
module irq_mask_bank
  import irq_ctrl_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCPU-1:0]       wr_en,
  input  logic [ISR_W-1:0]      wr_data,
  output logic [NCPU*ISR_W-1:0] imr_q
);
  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [ISR_W-1:0] mask_q;
    logic [ISR_W-1:0] mask_d;

    always_comb mask_d = wr_en[c] ? wr_data : mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_d;
    end

    assign imr_q[c*ISR_W +: ISR_W] = mask_q;
  end
endmodule

// File: rtl/irq_line_map.sv
`timescale 1ns/1ps
module irq_line_map
  import irq_ctrl_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ISR_W-1:0]      isr_q,
  input  logic [NCPU*ISR_W-1:0] imr_q,
  output logic [NCPU*NLINE-1:0] cpu_ip
);
  logic [NCPU*NLINE-1:0] ip_d;
  logic [NCPU*NLINE-1:0] ip_q;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [ISR_W-1:0] live;
    assign live = isr_q & imr_q[c*ISR_W +: ISR_W];
    for (genvar l = 0; l < NLINE; l++) begin : g_line
      assign ip_d[c*NLINE + l] = |(live & grp_mask(l));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ip_q <= '0;
    else        ip_q <= ip_d;
  end

  assign cpu_ip = ip_q;
endmodule

// File: rtl/irq_status_ctrl.sv
`timescale 1ns/1ps
module irq_status_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NCPU     = 4,
  parameter int NEVT     = 4,
  parameter int EVT_BASE = 59,
  parameter int REM_AW   = 8,
  parameter int REM_DW   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  loc_valid,
  input  logic                  loc_write,
  input  logic [LOC_AW-1:0]     loc_addr,
  input  logic [ISR_W-1:0]      loc_wdata,
  output logic [ISR_W-1:0]      loc_rdata,
  input  logic                  rem_valid,
  input  logic [REM_AW-1:0]     rem_addr,
  input  logic [REM_DW-1:0]     rem_wdata,
  input  logic [NEVT-1:0]       hw_evt,
  output logic [NCPU*NLINE-1:0] cpu_ip
);
  logic                  lwr, lrd;
  logic                  isr_wr;
  logic [ISR_W-1:0]      loc_set, loc_clr;
  logic [ISR_W-1:0]      rem_set, rem_clr;
  logic [NCPU-1:0]       imr_we;
  logic [ISR_W-1:0]      isr_q;
  logic [NCPU*ISR_W-1:0] imr_q;
  logic [ISR_W-1:0]      rdata_d, rdata_q;

  always_comb begin
    lwr     = loc_valid &  loc_write;
    lrd     = loc_valid & ~loc_write;
    isr_wr  = lwr && (loc_addr == A_ISR);
    loc_set = (lwr && (loc_addr == A_SET)) ? loc_wdata : '0;
    loc_clr = (lwr && (loc_addr == A_CLR)) ? loc_wdata : '0;
    for (int c = 0; c < NCPU; c++)
      imr_we[c] = lwr && (loc_addr == LOC_AW'(A_MASK + c));
  end

  irq_remote_decode #(.REM_AW(REM_AW), .REM_DW(REM_DW)) u_rdec (
    .rem_valid (rem_valid),
    .rem_addr  (rem_addr),
    .rem_wdata (rem_wdata),
    .rem_set   (rem_set),
    .rem_clr   (rem_clr)
  );

  irq_isr_core #(.NEVT(NEVT), .EVT_BASE(EVT_BASE)) u_isr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (isr_wr),
    .wr_data (loc_wdata),
    .set_vec (loc_set | rem_set),
    .clr_vec (loc_clr | rem_clr),
    .hw_evt  (hw_evt),
    .isr_q   (isr_q)
  );

  irq_mask_bank #(.NCPU(NCPU)) u_imr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (imr_we),
    .wr_data (loc_wdata),
    .imr_q   (imr_q)
  );

  irq_line_map #(.NCPU(NCPU)) u_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .isr_q  (isr_q),
    .imr_q  (imr_q),
    .cpu_ip (cpu_ip)
  );

  // read path: registered, enabled by a read request
  always_comb begin
    rdata_d = rdata_q;
    if (lrd) begin
      rdata_d = '0;
      if (loc_addr <= A_CLR) rdata_d = isr_q;
      for (int c = 0; c < NCPU; c++)
        if (loc_addr == LOC_AW'(A_MASK + c)) rdata_d = imr_q[c*ISR_W +: ISR_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign loc_rdata = rdata_q;
endmodule

// File: rtl/irq_status_ctrl_chk.sv
`timescale 1ns/1ps
module irq_status_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int NCPU     = 4,
  parameter int NEVT     = 4,
  parameter int EVT_BASE = 59,
  parameter int REM_AW   = 8,
  parameter int REM_DW   = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  loc_valid,
  input logic                  loc_write,
  input logic [LOC_AW-1:0]     loc_addr,
  input logic [ISR_W-1:0]      loc_wdata,
  input logic                  rem_valid,
  input logic [REM_AW-1:0]     rem_addr,
  input logic [REM_DW-1:0]     rem_wdata,
  input logic [NEVT-1:0]       hw_evt,
  input logic [NCPU*NLINE-1:0] cpu_ip,
  input logic [ISR_W-1:0]      isr_q,
  input logic [NCPU*ISR_W-1:0] imr_q
);
  // R3
  set_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_valid && loc_write && loc_addr == A_SET)
    |=> ((isr_q & $past(loc_wdata)) == $past(loc_wdata)));

  // R5
  remote_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_valid && rem_addr == REM_AW'(8'h80) && rem_wdata[8])
    |=> isr_q[$past(rem_wdata[5:0])]);

  // R7
  mask0_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_valid && loc_write && loc_addr == LOC_AW'(A_MASK))
    |=> (imr_q[ISR_W-1:0] == $past(loc_wdata)));

  // R8
  masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(imr_q[ISR_W-1:0]) == '0) |-> (cpu_ip[NLINE-1:0] == '0));

  // R9
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(isr_q) == '0) |-> (cpu_ip == '0));

  // R10
  evt_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_evt[0] && !$past(hw_evt[0])) |=> isr_q[EVT_BASE]);
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(
  .NCPU(NCPU), .NEVT(NEVT), .EVT_BASE(EVT_BASE), .REM_AW(REM_AW), .REM_DW(REM_DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .loc_valid(loc_valid), .loc_write(loc_write),
  .loc_addr(loc_addr), .loc_wdata(loc_wdata), .rem_valid(rem_valid),
  .rem_addr(rem_addr), .rem_wdata(rem_wdata), .hw_evt(hw_evt),
  .cpu_ip(cpu_ip), .isr_q(isr_q), .imr_q(imr_q)
);

// File: tb/tb_irq_status_ctrl.sv
`timescale 1ns/1ps
module tb_irq_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        loc_valid, loc_write;
  logic [2:0]  loc_addr;
  logic [63:0] loc_wdata, loc_rdata;
  logic        rem_valid;
  logic [7:0]  rem_addr;
  logic [15:0] rem_wdata;
  logic [3:0]  hw_evt;
  logic [23:0] cpu_ip;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] exp_isr;
  logic [63:0] exp_imr [4];

  always #2.5 clk = ~clk;

  irq_status_ctrl dut (
    .clk(clk), .rst_n(rst_n), .loc_valid(loc_valid), .loc_write(loc_write),
    .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
    .rem_valid(rem_valid), .rem_addr(rem_addr), .rem_wdata(rem_wdata),
    .hw_evt(hw_evt), .cpu_ip(cpu_ip)
  );

  function automatic int line_of(int b);
    if (b < 16) return 0;
    if (b < 32) return 1;
    if (b < 48) return 2;
    if (b < 56) return 3;
    if (b < 60) return 4;
    return 5;
  endfunction

  function automatic logic [23:0] exp_lines();
    logic [23:0] r = '0;
    for (int c = 0; c < 4; c++)
      for (int b = 0; b < 64; b++)
        if (exp_isr[b] && exp_imr[c][b]) r[c*6 + line_of(b)] = 1'b1;
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic loc_wr(logic [2:0] a, logic [63:0] d);
    @(negedge clk);
    loc_valid = 1; loc_write = 1; loc_addr = a; loc_wdata = d;
    @(negedge clk);
    loc_valid = 0; loc_write = 0;
  endtask

  task automatic loc_rd(logic [2:0] a, output logic [63:0] d);
    @(negedge clk);
    loc_valid = 1; loc_write = 0; loc_addr = a;
    @(negedge clk);
    loc_valid = 0;
    d = loc_rdata;
  endtask

  task automatic rem_wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    rem_valid = 1; rem_addr = a; rem_wdata = d;
    @(negedge clk);
    rem_valid = 0;
  endtask

  task automatic chk_isr(string req);
    logic [63:0] d;
    loc_rd(3'd0, d);
    check(req, d, exp_isr);
  endtask

  task automatic t_reset();
    logic [63:0] d;
    check("R1 lines", 64'(cpu_ip), 64'h0);
    check("R1 rdata", loc_rdata, 64'h0);
    chk_isr("R1 isr");
    for (int c = 0; c < 4; c++) begin
      loc_rd(3'(4 + c), d);
      check("R1 mask", d, 64'h0);
    end
  endtask

  task automatic t_masks();
    logic [63:0] d;
    for (int c = 0; c < 4; c++) begin
      exp_imr[c] = 64'h0123_4567_89AB_CDEF ^ (64'h1111 << (c * 8));
      loc_wr(3'(4 + c), exp_imr[c]);
    end
    for (int c = 0; c < 4; c++) begin
      loc_rd(3'(4 + c), d);
      check("R7 R11 mask readback", d, exp_imr[c]);
    end
  endtask

  task automatic t_direct();
    exp_isr = 64'hA5A5_0F0F_3C3C_9696;
    loc_wr(3'd0, exp_isr);
    chk_isr("R2 direct write");
    exp_isr = 64'h0000_0000_0000_000F;
    loc_wr(3'd0, exp_isr);
    chk_isr("R2 overwrite");
  endtask

  task automatic t_setclr();
    logic [63:0] d;
    loc_wr(3'd1, 64'h8000_0000_0000_00F0);
    exp_isr = 64'h8000_0000_0000_00FF;
    chk_isr("R3 set port");
    loc_wr(3'd2, 64'h0000_0000_0000_000F);
    exp_isr = 64'h8000_0000_0000_00F0;
    chk_isr("R4 clear port");
    loc_wr(3'd1, 64'h0);
    loc_rd(3'd1, d);
    check("R3 zero set / R11 alias", d, exp_isr);
  endtask

  task automatic t_remote();
    rem_wr(8'h80, 16'h0100 | 16'd33);
    exp_isr[33] = 1'b1;
    chk_isr("R5 remote set");
    rem_wr(8'h80, 16'd4);
    exp_isr[4] = 1'b0;
    chk_isr("R5 remote clear");
    rem_wr(8'h84, 16'h0100 | 16'd20);
    rem_wr(8'h00, 16'd33);
    chk_isr("R5 wrong address ignored");
  endtask

  task automatic t_race();
    // local clear of bit 10 and remote set of bit 10 together
    loc_wr(3'd0, 64'h400);
    @(negedge clk);
    loc_valid = 1; loc_write = 1; loc_addr = 3'd2; loc_wdata = 64'h400;
    rem_valid = 1; rem_addr = 8'h80; rem_wdata = 16'h0100 | 16'd10;
    @(negedge clk);
    loc_valid = 0; loc_write = 0; rem_valid = 0;
    exp_isr = 64'h400;
    chk_isr("R6 remote set beats local clear");
    // local set of bit 12 and remote clear of bit 12 together
    @(negedge clk);
    loc_valid = 1; loc_write = 1; loc_addr = 3'd1; loc_wdata = 64'h1000;
    rem_valid = 1; rem_addr = 8'h80; rem_wdata = 16'd12;
    @(negedge clk);
    loc_valid = 0; loc_write = 0; rem_valid = 0;
    exp_isr = 64'h1400;
    chk_isr("R6 local set beats remote clear");
  endtask

  task automatic t_lines();
    exp_imr[0] = '1;
    exp_imr[1] = 64'hF000_0000_0000_0000;
    exp_imr[2] = 64'h0;
    exp_imr[3] = 64'h0004_0000_0000_0000;
    for (int c = 0; c < 4; c++) loc_wr(3'(4 + c), exp_imr[c]);
    exp_isr = (64'h1 << 5) | (64'h1 << 50) | (64'h1 << 61);
    loc_wr(3'd0, exp_isr);
    @(negedge clk);
    check("R8 fan-out pattern A", 64'(cpu_ip), 64'(exp_lines()));
    exp_isr = (64'h1 << 16) | (64'h1 << 47) | (64'h1 << 56);
    loc_wr(3'd0, exp_isr);
    @(negedge clk);
    check("R8 group edges pattern B", 64'(cpu_ip), 64'(exp_lines()));
  endtask

  task automatic t_latency();
    logic [23:0] old;
    old = exp_lines();
    exp_isr = 64'h0000_0000_0000_FFFF;
    loc_wr(3'd0, exp_isr);
    check("R9 lines hold for one cycle", 64'(cpu_ip), 64'(old));
    @(negedge clk);
    check("R9 lines follow one cycle later", 64'(cpu_ip), 64'(exp_lines()));
    old = exp_lines();
    exp_imr[2] = 64'h1;
    loc_wr(3'd6, exp_imr[2]);
    check("R9 mask change delayed", 64'(cpu_ip), 64'(old));
    @(negedge clk);
    check("R9 mask change applied", 64'(cpu_ip), 64'(exp_lines()));
  endtask

  task automatic t_events();
    exp_isr = 64'h0;
    loc_wr(3'd0, exp_isr);
    @(negedge clk);
    hw_evt = 4'b0010;
    @(negedge clk);
    exp_isr[60] = 1'b1;
    chk_isr("R10 error edge sets bit 60");
    loc_wr(3'd2, 64'h1 << 60);
    exp_isr[60] = 1'b0;
    repeat (3) @(negedge clk);
    chk_isr("R10 held level does not re-set");
    // timer edge in the same cycle as a local clear of its bit
    @(negedge clk);
    hw_evt = 4'b0011;
    loc_valid = 1; loc_write = 1; loc_addr = 3'd2; loc_wdata = 64'h1 << 59;
    @(negedge clk);
    loc_valid = 0; loc_write = 0;
    hw_evt = 4'b0000;
    exp_isr[59] = 1'b1;
    chk_isr("R10 R6 timer edge beats clear");
    @(negedge clk);
    check("R10 timer on line 4 of CPU0", 64'(cpu_ip[4]), 64'(exp_lines() >> 4) & 64'h1);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; loc_valid = 0; loc_write = 0; loc_addr = '0; loc_wdata = '0;
    rem_valid = 0; rem_addr = '0; rem_wdata = '0; hw_evt = '0;
    exp_isr = '0;
    for (int c = 0; c < 4; c++) exp_imr[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_masks();
    t_direct();
    t_setclr();
    t_remote();
    t_race();
    t_lines();
    t_latency();
    t_events();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule